// File: doc/BRIEF.md
# Buffer-Level Clock Trim Controller

This block closes a feedback loop from the fill level of a streaming-audio sample FIFO to the fractional trim word of the playback master-clock divider. Samples reach the FIFO in bursts once per 1 ms frame. The playback side drains them at the local sample rate. Any mismatch between the two clock domains slowly fills or empties the buffer. Even one lost or repeated sample is heard as a click, so the drain side must never run dry and the buffer must never overflow.

Once per frame tick the controller sorts the fill level into one of three zones: below a lower threshold, above an upper threshold, or inside the window between them. It then moves the trim by at most one unit. A lower trim gives a faster drain clock, and a higher trim gives a slower one. The trim is kept between a programmable minimum and maximum. The default bounds of 459 and 468 around a centre of 464 limit the sample-rate swing to about ±0.2 %, which is inaudible.

After reset or a stream restart the trim holds its centre value until the FIFO first reaches half full. Sticky flags show when the loop has run out of range, that is, when the trim is already at a bound but the fill level still asks for more correction.

Top module: `audio_trim_ctl`

## Requirements
- R1: After reset, and in the cycle after `stream_start`, `trim_out` equals NOMINAL (default 464), and `armed`, `rail_lo_flag` and `rail_hi_flag` are 0.
- R2: `armed` goes to 1 on the clock edge where `fill_level >= DEPTH/2` (default 128) is sampled, and stays 1 until reset or restart. While `armed` is 0, frame ticks leave `trim_out` at NOMINAL.
- R3: On a frame tick while armed, `fill_level > win_hi` lowers `trim_out` by 1 on the next edge, subject to R6.
- R4: On a frame tick while armed, `fill_level < win_lo` raises `trim_out` by 1 on the next edge, subject to R6.
- R5: On a frame tick while armed, `win_lo <= fill_level <= win_hi` (both ends inclusive) leaves `trim_out` unchanged when it already lies within the bounds.
- R6: The value loaded on an armed frame tick is clamped into [`trim_min`, `trim_max`]. A trim outside newly changed bounds is pulled to the nearest bound on the next armed tick.
- R7: `trim_out` changes only on edges where `frame_tick` or `stream_start` was high.
- R8: `rail_lo_flag` is set by an armed frame tick with `fill_level > win_hi` while `trim_out <= trim_min`. It then stays set until reset or restart.
- R9: `rail_hi_flag` is set by an armed frame tick with `fill_level < win_lo` while `trim_out >= trim_max`. It then stays set until reset or restart.
- R10: `stream_start` takes priority over a simultaneous `frame_tick` and over arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stream_start | input | 1 | Restart pulse: recentre trim, disarm, clear flags |
| frame_tick | input | 1 | One-cycle pulse per 1 ms frame |
| fill_level | input | FILL_W (9) | Current FIFO occupancy, 0..DEPTH |
| win_lo | input | FILL_W (9) | Lower fill threshold |
| win_hi | input | FILL_W (9) | Upper fill threshold |
| trim_min | input | TRIM_W (9) | Lowest allowed trim |
| trim_max | input | TRIM_W (9) | Highest allowed trim |
| trim_out | output | TRIM_W (9) | Fractional trim to the clock divider |
| armed | output | 1 | Loop active (FIFO has reached half full) |
| rail_lo_flag | output | 1 | Sticky: needed faster drain but trim at minimum |
| rail_hi_flag | output | 1 | Sticky: needed slower drain but trim at maximum |

## Verification
On every cycle the assertions check the following: the one-step moves in each zone, the hold inside the window, the clamp after any armed tick, the trim staying stable between ticks, the recentre on restart, the trim staying at its centre while disarmed, and the flags staying set. Some behaviours show only over long stretches of ticks, and only the bench scenarios can reveal them. These are the trim walking into a bound and the flag rising there, the full sweep of fill levels up and down against a running arithmetic model, the pull-in after the bounds are narrowed, and the ordering of restart against a simultaneous tick.

// File: rtl/trim_ctl_pkg.sv
// Shared types for the buffer-level trim controller.
// Assumes: nothing beyond standard SystemVerilog.
package trim_ctl_pkg;
    typedef enum logic [1:0] {
        ZONE_IN   = 2'd0,   // fill inside the window
        ZONE_LOW  = 2'd1,   // fill below lower threshold
        ZONE_HIGH = 2'd2    // fill above upper threshold
    } fill_zone_e;
endpackage

// File: rtl/fill_zone_cls.sv
// Classifies the FIFO fill level against the threshold window.
// Assumes win_lo <= win_hi; both ends of the window count as inside.
module fill_zone_cls
    import trim_ctl_pkg::*;
#(
    parameter int FILL_W = 9
) (
    input  logic [FILL_W-1:0] fill_level,
    input  logic [FILL_W-1:0] win_lo,
    input  logic [FILL_W-1:0] win_hi,
    output fill_zone_e        zone
);
    // Pure compare: high side wins if thresholds are inverted.
    always_comb begin
        if (fill_level > win_hi)      zone = ZONE_HIGH;
        else if (fill_level < win_lo) zone = ZONE_LOW;
        else                          zone = ZONE_IN;
    end
endmodule

// File: rtl/trim_step_reg.sv
// Holds the trim word, steps it by one per enabled tick and clamps it.
// Assumes step_en already includes the armed qualification; restart wins.
module trim_step_reg
    import trim_ctl_pkg::*;
#(
    parameter int TRIM_W  = 9,
    parameter int NOMINAL = 464
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step_en,
    input  fill_zone_e        zone,
    input  logic [TRIM_W-1:0] trim_min,
    input  logic [TRIM_W-1:0] trim_max,
    output logic [TRIM_W-1:0] trim_q
);
    localparam logic [TRIM_W-1:0] NOM_V = TRIM_W'(NOMINAL);

    logic [TRIM_W:0]   base;
    logic [TRIM_W-1:0] clamped;

    // Candidate value one step away, computed one bit wider to avoid wrap.
    always_comb begin
        unique case (zone)
            ZONE_HIGH: base = (trim_q == '0) ? '0 : {1'b0, trim_q} - 1'b1;
            ZONE_LOW:  base = {1'b0, trim_q} + 1'b1;
            default:   base = {1'b0, trim_q};
        endcase
    end

    // Clamp the candidate into the programmed bounds.
    always_comb begin
        if (base < {1'b0, trim_min})      clamped = trim_min;
        else if (base > {1'b0, trim_max}) clamped = trim_max;
        else                              clamped = base[TRIM_W-1:0];
    end

    // Trim register: recentre on reset/restart, update on enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) trim_q <= NOM_V;
        else if (step_en)      trim_q <= clamped;
    end

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !restart && zone == ZONE_HIGH && trim_q > trim_min && trim_q <= trim_max)
        |=> trim_q == $past(trim_q) - 1'b1);
    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !restart && zone == ZONE_LOW && trim_q < trim_max && trim_q >= trim_min)
        |=> trim_q == $past(trim_q) + 1'b1);
    // R5
    hold_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !restart && zone == ZONE_IN && trim_q >= trim_min && trim_q <= trim_max)
        |=> $stable(trim_q));
    // R6
    within_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !restart && trim_min <= trim_max)
        |=> (trim_q >= $past(trim_min) && trim_q <= $past(trim_max)));
    // R7
    quiet_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !restart) |=> $stable(trim_q));
    // R10
    restart_recentre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> trim_q == NOM_V);
endmodule

// File: rtl/bound_flag_reg.sv
// Sticky flags: the loop wanted more correction than the bounds allow.
// Assumes step_en already includes the armed qualification; restart clears.
module bound_flag_reg
    import trim_ctl_pkg::*;
#(
    parameter int TRIM_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step_en,
    input  fill_zone_e        zone,
    input  logic [TRIM_W-1:0] trim_q,
    input  logic [TRIM_W-1:0] trim_min,
    input  logic [TRIM_W-1:0] trim_max,
    output logic              rail_lo,
    output logic              rail_hi
);
    logic hit_lo, hit_hi;

    // Saturation events for this tick.
    always_comb begin
        hit_lo = step_en && (zone == ZONE_HIGH) && (trim_q <= trim_min);
        hit_hi = step_en && (zone == ZONE_LOW)  && (trim_q >= trim_max);
    end

    // Flag registers: set on event, clear only on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            rail_lo <= 1'b0;
            rail_hi <= 1'b0;
        end else begin
            rail_lo <= rail_lo | hit_lo;
            rail_hi <= rail_hi | hit_hi;
        end
    end

    // R8
    rail_lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_lo && !restart) |=> rail_lo);
    // R8
    rail_lo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !restart && zone == ZONE_HIGH && trim_q <= trim_min) |=> rail_lo);
    // R9
    rail_hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_hi && !restart) |=> rail_hi);
    // R9
    rail_hi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !restart && zone == ZONE_LOW && trim_q >= trim_max) |=> rail_hi);
endmodule

// File: rtl/audio_trim_ctl.sv
// Top of the buffer-level clock trim controller: arms on first half-full,
// then steps the divider trim once per frame tick to centre the FIFO.
// Assumes frame_tick is a one-cycle pulse and fill_level is synchronous to clk.
module audio_trim_ctl
    import trim_ctl_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int FILL_W  = $clog2(DEPTH + 1),
    parameter int TRIM_W  = 9,
    parameter int NOMINAL = 464
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stream_start,
    input  logic              frame_tick,
    input  logic [FILL_W-1:0] fill_level,
    input  logic [FILL_W-1:0] win_lo,
    input  logic [FILL_W-1:0] win_hi,
    input  logic [TRIM_W-1:0] trim_min,
    input  logic [TRIM_W-1:0] trim_max,
    output logic [TRIM_W-1:0] trim_out,
    output logic              armed,
    output logic              rail_lo_flag,
    output logic              rail_hi_flag
);
    localparam logic [FILL_W-1:0] HALF_LVL = FILL_W'(DEPTH / 2);

    fill_zone_e zone;
    logic       armed_q;
    logic       step_en;

    // Arm the loop once the buffer first reaches half full.
    always_ff @(posedge clk) begin
        if (!rst_n || stream_start)     armed_q <= 1'b0;
        else if (fill_level >= HALF_LVL) armed_q <= 1'b1;
    end

    // Only frame ticks of an armed loop may move the trim.
    always_comb step_en = frame_tick && armed_q;

    fill_zone_cls #(.FILL_W(FILL_W)) zone_i (
        .fill_level (fill_level),
        .win_lo     (win_lo),
        .win_hi     (win_hi),
        .zone       (zone)
    );

    trim_step_reg #(.TRIM_W(TRIM_W), .NOMINAL(NOMINAL)) step_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (stream_start),
        .step_en  (step_en),
        .zone     (zone),
        .trim_min (trim_min),
        .trim_max (trim_max),
        .trim_q   (trim_out)
    );

    bound_flag_reg #(.TRIM_W(TRIM_W)) flag_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (stream_start),
        .step_en  (step_en),
        .zone     (zone),
        .trim_q   (trim_out),
        .trim_min (trim_min),
        .trim_max (trim_max),
        .rail_lo  (rail_lo_flag),
        .rail_hi  (rail_hi_flag)
    );

    always_comb armed = armed_q;

    // R2
    unarmed_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> trim_out == TRIM_W'(NOMINAL));
    // R2
    arm_on_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level >= HALF_LVL && !stream_start) |=> armed_q);
    // R1
    restart_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stream_start |=> (!armed_q && !rail_lo_flag && !rail_hi_flag));
endmodule

// File: tb/audio_trim_ctl_tb_top.sv
// Self-checking bench: drives frame ticks over sweeps of fill level and
// compares every output against an arithmetic model built from the brief.
module audio_trim_ctl_tb_top;
    localparam int DEPTH = 256;
    localparam int FW    = 9;
    localparam int TW    = 9;
    localparam int NOM   = 464;
    localparam int HALF  = DEPTH / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stream_start = 1'b0;
    logic          frame_tick = 1'b0;
    logic [FW-1:0] fill_level = '0;
    logic [FW-1:0] win_lo = FW'(112);
    logic [FW-1:0] win_hi = FW'(144);
    logic [TW-1:0] trim_min = TW'(459);
    logic [TW-1:0] trim_max = TW'(468);
    logic [TW-1:0] trim_out;
    logic          armed, rail_lo_flag, rail_hi_flag;

    int checks = 0, failures = 0;
    int e_trim = NOM, e_armed = 0, e_lo = 0, e_hi = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    audio_trim_ctl #(.DEPTH(DEPTH), .TRIM_W(TW), .NOMINAL(NOM)) dut_i (
        .clk(clk), .rst_n(rst_n), .stream_start(stream_start), .frame_tick(frame_tick),
        .fill_level(fill_level), .win_lo(win_lo), .win_hi(win_hi),
        .trim_min(trim_min), .trim_max(trim_max), .trim_out(trim_out),
        .armed(armed), .rail_lo_flag(rail_lo_flag), .rail_hi_flag(rail_hi_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "trim_out", int'(trim_out), e_trim);
        chk(req, "armed", int'(armed), e_armed);
        chk(req, "rail_lo_flag", int'(rail_lo_flag), e_lo);
        chk(req, "rail_hi_flag", int'(rail_hi_flag), e_hi);
    endtask

    // One clock: drive at negedge, update the model at the edge, check at next negedge.
    task automatic step(input bit tick, input bit start, input int fill, input string req);
        int base;
        fill_level   = FW'(fill);
        frame_tick   = tick;
        stream_start = start;
        @(posedge clk);
        if (start) begin
            e_trim = NOM; e_armed = 0; e_lo = 0; e_hi = 0;
        end else begin
            if (tick && e_armed == 1) begin
                base = e_trim;
                if (fill > int'(win_hi)) begin
                    if (e_trim <= int'(trim_min)) e_lo = 1;
                    base = (e_trim == 0) ? 0 : e_trim - 1;
                end else if (fill < int'(win_lo)) begin
                    if (e_trim >= int'(trim_max)) e_hi = 1;
                    base = e_trim + 1;
                end
                if (base < int'(trim_min)) base = int'(trim_min);
                else if (base > int'(trim_max)) base = int'(trim_max);
                e_trim = base;
            end
            if (fill >= HALF) e_armed = 1;
        end
        @(negedge clk);
        frame_tick   = 1'b0;
        stream_start = 1'b0;
        check_all(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");                                   // reset state
        for (int i = 0; i < 3; i++) step(1, 0, 50, "R2");  // unarmed ticks ignored
        step(1, 0, HALF - 1, "R2");                        // just below half: still unarmed
        step(0, 0, HALF, "R2");                            // arms without a tick
        for (int i = 0; i < 8; i++) step(1, 0, 200, "R3"); // walk down, hit minimum
        chk("R8", "rail_lo_flag after saturating", int'(rail_lo_flag), 1);
        for (int i = 0; i < 5; i++) step(0, 0, 0, "R7");   // no tick: no motion
        for (int i = 0; i < 12; i++) step(1, 0, 0, "R4");  // walk up, hit maximum
        chk("R9", "rail_hi_flag after saturating", int'(rail_hi_flag), 1);
        for (int f = 112; f <= 144; f++) step(1, 0, f, "R5");
        for (int f = 0; f <= DEPTH; f++) step(1, 0, f, "R6");
        for (int f = DEPTH; f >= 0; f--) step(1, 0, f, "R6");
        for (int f = 145; f <= 150; f++) step(1, 0, f, "R3");
        for (int f = 105; f <= 111; f++) step(1, 0, f, "R4");
        trim_min = TW'(462); trim_max = TW'(465);
        step(1, 0, 128, "R6");                             // pulled into narrowed bounds
        chk("R6", "trim in narrowed bounds", int'(trim_out >= 462 && trim_out <= 465), 1);
        trim_min = TW'(459); trim_max = TW'(468);
        step(1, 1, 0, "R10");                              // restart beats tick
        chk("R10", "trim after restart+tick", int'(trim_out), NOM);
        step(1, 1, 200, "R1");                             // restart beats arming
        for (int i = 0; i < 3; i++) step(1, 0, 10, "R2");
        step(0, 0, 255, "R2");
        step(1, 0, 255, "R3");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule